// File: doc/BRIEF.md
# Bit-Serial Packet Crossbar Router

This block links sixteen bit-serial senders to sixteen bit-serial receivers. Every input and every output is a trio of wires: a data bit, an active-low frame strobe and an active-low valid strobe. All three are gathered into 16-bit vectors, and bit k of each vector belongs to port k. A sender opens a packet by pulling its frame strobe low. It then sends a 4-bit destination number, least significant bit first, and follows that with five idle padding cycles. After the padding comes a payload of any length. A payload bit counts only when the valid strobe is low. The sender marks its last payload bit by raising the frame strobe in that same cycle.

When an input reaches its payload phase it asks for its destination output. A round-robin arbiter on each output picks one requester and keeps the output locked to it until that packet's frame ends. From that point the output copies the input's frame and valid levels one clock later. An input that is still waiting sees its busy line low. The sender must then hold back payload, keeping valid high, until busy returns high. In this way no payload bit is lost, and the router needs no packet storage.

Top module: `serial_xbar`

## Requirements
- R1: During a synchronous active-high reset, and on the first cycle after it, every frame_out_n, valid_out_n and busy_n bit is 1 and every data_out bit is 0.
- R2: The cycle in which frame_in_n falls is header cycle 0. The destination bits arrive on data_in in cycles 0 to 3, least significant bit first. Cycles 4 to 8 are padding. The payload phase begins at cycle 9, and no output responds to the input before that cycle.
- R3: While input i is connected to output o in cycle t, frame_out_n[o] in cycle t+1 equals frame_in_n[i] from cycle t.
- R4: A bit that input i presents with valid_in_n[i] high is dropped. The connected output shows valid_out_n high with data_out 0. More generally, data_out[o] is 0 whenever valid_out_n[o] is 1.
- R5: An output that has no connected input holds frame_out_n=1, valid_out_n=1 and data_out=0.
- R6: An input that wins a free output in its first payload cycle is connected in that same cycle. Its frame therefore appears on the output one cycle later (header cycle 10), and valid_out_n and data_out follow that input with the same one-cycle delay.
- R7: A free output grants the first requesting input found when counting upward, with wrap-around, from its pointer. After a grant the pointer moves to the winner's index plus one, modulo 16. Reset sets every pointer to 0.
- R8: An output stays locked to its granted input until the cycle in which that input's frame_in_n is high during payload. The output can be granted to another input no earlier than the next cycle.
- R9: busy_n[i] is 0 exactly when input i is in its payload phase and is not connected to an output.
- R10: When the sender drives valid low only while busy_n is high, every payload bit reaches its destination. The number of valid bits seen on each output equals the number sent to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_in_n | input | 16 | Active-low frame strobe per input |
| valid_in_n | input | 16 | Active-low payload-valid strobe per input |
| data_in | input | 16 | Serial data bit per input |
| busy_n | output | 16 | Active-low wait indication per input |
| frame_out_n | output | 16 | Active-low frame strobe per output, registered |
| valid_out_n | output | 16 | Active-low valid strobe per output, registered |
| data_out | output | 16 | Serial data bit per output, registered |

## Verification
The bench builds the router with its default sixteen ports and five padding cycles. This makes the full 4-bit address space reachable, along with the pointer wrapping from a high index back toward low indices. It also covers the case where all sixteen inputs run at once to mirrored outputs. A behavioural model, holding per-input phase counters and per-output owner and pointer integers, predicts busy and all three output vectors on every clock. Directed scenarios add three-way contention, a single-bit payload, a dropped invalid bit and a wrap-around grant.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_HDR,
    RX_PAY
  } rx_state_e;
endpackage

// File: rtl/rx_port.sv
// Per-input header decoder: collects the destination, waits out the padding,
// then flags the payload phase until the frame strobe rises.
module rx_port #(
  parameter int AW  = 4,
  parameter int PAD = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_n,
  input  logic          data,
  output logic          pay,
  output logic [AW-1:0] dest
);
  import xbar_pkg::*;

  localparam int HDR_LAST = AW + PAD - 1;
  localparam int CW       = $clog2(AW + PAD + 1);

  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] dest_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      dest_q <= '0;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (!frame_n) begin
            dest_q    <= '0;
            dest_q[0] <= data;
            cnt_q     <= CW'(1);
            st_q      <= RX_HDR;
          end
        end
        RX_HDR: begin
          if (frame_n) begin
            st_q <= RX_IDLE;
          end else begin
            for (int b = 1; b < AW; b++) begin
              if (cnt_q == CW'(b)) dest_q[b] <= data;
            end
            if (cnt_q == CW'(HDR_LAST)) st_q <= RX_PAY;
            cnt_q <= cnt_q + CW'(1);
          end
        end
        RX_PAY: begin
          if (frame_n) st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign pay  = (st_q == RX_PAY);
  assign dest = dest_q;
endmodule

// File: rtl/rr_arbiter.sv
// Per-output round-robin arbiter with packet lock. N must be a power of two.
module rr_arbiter #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] done,
  output logic [N-1:0] sel
);
  localparam int IW = $clog2(N);

  logic          locked_q;
  logic [N-1:0]  owner_q;
  logic [IW-1:0] ptr_q;
  logic [N-1:0]  pick;
  logic [IW-1:0] pick_idx;
  logic          found;

  always_comb begin
    found    = 1'b0;
    pick_idx = ptr_q;
    for (int k = 0; k < N; k++) begin
      logic [IW-1:0] idx;
      idx = ptr_q + IW'(k);
      if (!found && req[idx]) begin
        found    = 1'b1;
        pick_idx = idx;
      end
    end
    pick = found ? (N'(1) << pick_idx) : '0;
  end

  assign sel = locked_q ? owner_q : pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      ptr_q    <= '0;
    end else if (locked_q) begin
      if (|(owner_q & done)) locked_q <= 1'b0;
    end else if (found) begin
      ptr_q    <= pick_idx + IW'(1);
      owner_q  <= pick;
      locked_q <= ~|(pick & done);
    end
  end
endmodule

// File: rtl/tx_port.sv
// Per-output registered stage: copies the selected input's strobes and
// masks data that is not qualified by valid.
module tx_port #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] frame_n,
  input  logic [N-1:0] valid_n,
  input  logic [N-1:0] data,
  output logic         frame_out_n,
  output logic         valid_out_n,
  output logic         data_out
);
  logic f_low, v_low, d_hi;

  always_comb begin
    f_low = |(sel & ~frame_n);
    v_low = |(sel & ~valid_n);
    d_hi  = |(sel & ~valid_n & data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_out_n <= 1'b1;
      valid_out_n <= 1'b1;
      data_out    <= 1'b0;
    end else begin
      frame_out_n <= ~f_low;
      valid_out_n <= ~v_low;
      data_out    <= d_hi;
    end
  end
endmodule

// File: rtl/serial_xbar.sv
module serial_xbar #(
  parameter int NPORT      = 16,
  parameter int PAD_CYCLES = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] frame_in_n,
  input  logic [NPORT-1:0] valid_in_n,
  input  logic [NPORT-1:0] data_in,
  output logic [NPORT-1:0] busy_n,
  output logic [NPORT-1:0] frame_out_n,
  output logic [NPORT-1:0] valid_out_n,
  output logic [NPORT-1:0] data_out
);
  localparam int AW = $clog2(NPORT);

  logic [NPORT-1:0] pay;
  logic [NPORT-1:0] done;
  logic [NPORT-1:0] conn;
  logic [AW-1:0]    dest [NPORT];
  logic [NPORT-1:0] sel  [NPORT];

  for (genvar i = 0; i < NPORT; i++) begin : g_rx
    rx_port #(.AW(AW), .PAD(PAD_CYCLES)) u_rx (
      .clk     (clk),
      .rst     (rst),
      .frame_n (frame_in_n[i]),
      .data    (data_in[i]),
      .pay     (pay[i]),
      .dest    (dest[i])
    );
  end

  assign done = pay & frame_in_n;

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [NPORT-1:0] req_v;
    logic [NPORT-1:0] sel_v;

    always_comb begin
      for (int i = 0; i < NPORT; i++) begin
        req_v[i] = pay[i] && (dest[i] == AW'(o));
      end
    end

    rr_arbiter #(.N(NPORT)) u_arb (
      .clk  (clk),
      .rst  (rst),
      .req  (req_v),
      .done (done),
      .sel  (sel_v)
    );

    assign sel[o] = sel_v;

    tx_port #(.N(NPORT)) u_tx (
      .clk         (clk),
      .rst         (rst),
      .sel         (sel_v),
      .frame_n     (frame_in_n),
      .valid_n     (valid_in_n),
      .data        (data_in),
      .frame_out_n (frame_out_n[o]),
      .valid_out_n (valid_out_n[o]),
      .data_out    (data_out[o])
    );
  end

  always_comb begin
    conn = '0;
    for (int o = 0; o < NPORT; o++) begin
      conn = conn | sel[o];
    end
  end

  assign busy_n = ~(pay & ~conn);
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
  parameter int NPORT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [NPORT-1:0] frame_in_n,
  input logic [NPORT-1:0] valid_in_n,
  input logic [NPORT-1:0] busy_n,
  input logic [NPORT-1:0] frame_out_n,
  input logic [NPORT-1:0] valid_out_n,
  input logic [NPORT-1:0] data_out
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> ((&frame_out_n) && (&valid_out_n) && (data_out == '0) && (&busy_n))); // R1

  AST_DROP_INVALID: assert property (@(posedge clk) disable iff (rst)
    (data_out & valid_out_n) == '0); // R4

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $countones(~frame_out_n) <= $past($countones(~frame_in_n))); // R3

  AST_NO_EXTRA_BITS: assert property (@(posedge clk) disable iff (rst)
    $countones(~valid_out_n) <= $past($countones(~valid_in_n))); // R10

  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    ((~busy_n) & $past(frame_in_n)) == '0); // R9
endmodule

bind serial_xbar xbar_checker #(.NPORT(NPORT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_in_n  (frame_in_n),
  .valid_in_n  (valid_in_n),
  .busy_n      (busy_n),
  .frame_out_n (frame_out_n),
  .valid_out_n (valid_out_n),
  .data_out    (data_out)
);

// File: tb/serial_xbar_test.sv
module serial_xbar_test;
  localparam int N    = 16;
  localparam int PADC = 5;
  localparam int HDRC = 4 + PADC;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] fin_n, vin_n, din;
  logic [N-1:0] busy_n, fout_n, vout_n, dout;

  serial_xbar #(.NPORT(N), .PAD_CYCLES(PADC)) uut (
    .clk         (clk),
    .rst         (rst),
    .frame_in_n  (fin_n),
    .valid_in_n  (vin_n),
    .data_in     (din),
    .busy_n      (busy_n),
    .frame_out_n (fout_n),
    .valid_out_n (vout_n),
    .data_out    (dout)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // sender state
  int s_st[N], s_cnt[N], s_dest[N], s_len[N], s_sent[N], s_bub[N];
  bit pend[N];
  int p_dest[N], p_len[N], p_bub[N];
  int sent_bits[N], rcv_bits[N];

  // reference model state
  int m_st[N], m_cnt[N], m_dest[N], m_own[N], m_ptr[N];
  logic [N-1:0] e_f, e_v, e_d;
  bit armed = 1'b0;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_pkt(input int i, input int d, input int len, input int bub);
    pend[i]   = 1'b1;
    p_dest[i] = d;
    p_len[i]  = len;
    p_bub[i]  = bub;
    sent_bits[d] += len;
  endtask

  always @(negedge clk) begin : step
    int sel[N];
    logic [N-1:0] e_busy;
    bit ends;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = 0; m_cnt[i] = 0; m_dest[i] = 0; m_own[i] = -1; m_ptr[i] = 0;
      end
      e_f = '1; e_v = '1; e_d = '0;
      armed = 1'b1;
    end else if (armed) begin
      // arbitration from model state
      for (int o = 0; o < N; o++) begin
        sel[o] = m_own[o];
        if (sel[o] < 0) begin
          for (int k = 0; k < N; k++) begin
            int c;
            c = (m_ptr[o] + k) % N;
            if (sel[o] < 0 && m_st[c] == 2 && m_dest[c] == o) sel[o] = c;
          end
        end
      end
      e_busy = '1;
      for (int i = 0; i < N; i++) begin
        bit cn;
        cn = 1'b0;
        for (int o = 0; o < N; o++) if (sel[o] == i) cn = 1'b1;
        if (m_st[i] == 2 && !cn) e_busy[i] = 1'b0;
      end
      check("R3 frame_out", fout_n, e_f);
      check("R6 valid_out", vout_n, e_v);
      check("R4 data_out", dout, e_d);
      check("R9 busy", busy_n, e_busy);
      for (int o = 0; o < N; o++) if (!vout_n[o]) rcv_bits[o]++;

      // senders
      for (int i = 0; i < N; i++) begin
        case (s_st[i])
          0: begin
            fin_n[i] = 1'b1; vin_n[i] = 1'b1; din[i] = 1'b0;
            if (pend[i]) begin
              pend[i] = 1'b0;
              s_dest[i] = p_dest[i]; s_len[i] = p_len[i]; s_bub[i] = p_bub[i];
              s_sent[i] = 0;
              fin_n[i] = 1'b0;
              din[i] = s_dest[i][0];
              s_st[i] = 1; s_cnt[i] = 1;
            end
          end
          1: begin
            fin_n[i] = 1'b0; vin_n[i] = 1'b1;
            din[i] = (s_cnt[i] < 4) ? s_dest[i][s_cnt[i]] : 1'b0;
            if (s_cnt[i] == HDRC - 1) s_st[i] = 2;
            s_cnt[i]++;
          end
          default: begin
            fin_n[i] = 1'b0;
            if (!busy_n[i]) begin
              vin_n[i] = 1'b1; din[i] = 1'b1;
            end else if (s_sent[i] == s_bub[i]) begin
              vin_n[i] = 1'b1; din[i] = 1'b1; s_bub[i] = -1;
            end else begin
              vin_n[i] = 1'b0;
              din[i] = ((i * 7 + s_sent[i] * 5) >> 1) & 1;
              s_sent[i]++;
              if (s_sent[i] == s_len[i]) begin
                fin_n[i] = 1'b1; s_st[i] = 0;
              end
            end
          end
        endcase
      end

      // expected outputs for next cycle and owner update
      for (int o = 0; o < N; o++) begin
        if (sel[o] >= 0) begin
          e_f[o] = fin_n[sel[o]];
          e_v[o] = vin_n[sel[o]];
          e_d[o] = vin_n[sel[o]] ? 1'b0 : din[sel[o]];
          ends = (m_st[sel[o]] == 2) && fin_n[sel[o]];
          if (m_own[o] < 0) begin
            m_ptr[o] = (sel[o] + 1) % N;
            m_own[o] = ends ? -1 : sel[o];
          end else if (ends) begin
            m_own[o] = -1;
          end
        end else begin
          e_f[o] = 1'b1; e_v[o] = 1'b1; e_d[o] = 1'b0;
        end
      end

      // input phase update
      for (int i = 0; i < N; i++) begin
        case (m_st[i])
          0: if (!fin_n[i]) begin
               m_dest[i] = din[i]; m_cnt[i] = 1; m_st[i] = 1;
             end
          1: if (fin_n[i]) m_st[i] = 0;
             else begin
               if (m_cnt[i] < 4) m_dest[i] = m_dest[i] | (int'(din[i]) << m_cnt[i]);
               if (m_cnt[i] == HDRC - 1) m_st[i] = 2;
               m_cnt[i]++;
             end
          default: if (fin_n[i]) m_st[i] = 0;
        endcase
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    fin_n = '1; vin_n = '1; din = '0;
    for (int i = 0; i < N; i++) begin
      s_st[i] = 0; s_cnt[i] = 0; s_dest[i] = 0; s_len[i] = 0; s_sent[i] = 0;
      s_bub[i] = -1; pend[i] = 1'b0; sent_bits[i] = 0; rcv_bits[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    check("R1 reset frame_out", fout_n, '1);
    check("R1 reset valid_out", vout_n, '1);
    check("R1 reset data_out", dout, '0);
    check("R1 reset busy", busy_n, '1);

    // single packet 3 -> 9 with one invalid bubble
    @(posedge clk); #1 start_pkt(3, 9, 6, 2);
    repeat (9) @(negedge clk); #1;
    check("R2 no output during padding", fout_n, '1);
    repeat (2) @(negedge clk); #1;
    check("R6 frame out at header cycle 10", fout_n, ~(16'h1 << 9));
    repeat (20) @(posedge clk);

    // three-way contention on output 7, parallel path 2 -> 1
    @(posedge clk); #1;
    start_pkt(0, 7, 4, -1);
    start_pkt(5, 7, 4, -1);
    start_pkt(12, 7, 4, -1);
    start_pkt(2, 1, 5, -1);
    repeat (10) @(negedge clk); #1;
    check("R7 first grant goes to input 0",
          {13'b0, busy_n[12], busy_n[5], busy_n[0]}, 16'h0001);
    repeat (2) @(negedge clk); #1;
    check("R8 output stays locked to input 0", {15'b0, busy_n[5]}, 16'h0000);
    repeat (40) @(posedge clk);

    // wrap-around: pointer of output 7 is now 13
    @(posedge clk); #1;
    start_pkt(1, 7, 3, -1);
    start_pkt(14, 7, 3, -1);
    repeat (10) @(negedge clk); #1;
    check("R7 wrap grant goes to input 14",
          {14'b0, busy_n[14], busy_n[1]}, 16'h0002);
    repeat (30) @(posedge clk);

    // single-bit payload
    @(posedge clk); #1 start_pkt(6, 0, 1, -1);
    repeat (25) @(posedge clk);

    // all inputs at once to mirrored outputs
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) start_pkt(i, N - 1 - i, 3 + (i % 4), (i % 3 == 0) ? 1 : -1);
    repeat (40) @(posedge clk);

    @(negedge clk); #1;
    check("R5 idle frame_out", fout_n, '1);
    check("R5 idle valid_out", vout_n, '1);
    check("R5 idle data_out", dout, '0);
    for (int o = 0; o < N; o++) check_int("R10 payload bits per output", rcv_bits[o], sent_bits[o]);
    finish_run();
  end
endmodule